// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind the bus interface of a parallel NOR flash and interprets the stream of write cycles it receives. Each write cycle carries an address and a 16-bit data word. The block recognises the two-cycle unlock prefix, the set-up code, and the confirm cycles that some commands need. When a command is complete, it raises a one-cycle operation strobe together with an operation kind and the latched address and data. The array, the program and erase engine, and the engines that serve reads all act on these strobes.

The block also keeps two pieces of state. The first is the read mode: normal array data, identification/autoselect data, or the query table. The second is a bypass flag. While bypass is set, program commands need no unlock prefix. A cycle that breaks the expected sequence abandons the command without a strobe and puts the read mode back to array data. If that cycle is itself a valid first unlock cycle, it also opens a new prefix.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and after it is released, op_valid is 0, rd_mode is 0 (array) and bypass_on is 0.
- R2: With no command pending, a single write of data F0h at any address gives kind 0 (read-array) and rd_mode 0. A write of 98h to address 055h gives kind 2 (query) and rd_mode 2. Other single cycles give no strobe, except those listed in R8.
- R3: After the prefix (AAh to 555h, then 55h to 2AAh), a third cycle to 555h decodes as follows. F0h gives kind 0. 90h gives kind 1 and rd_mode 1. 20h gives kind 13 and sets bypass_on. A0h, 40h, 60h and 80h wait for more cycles. Any other code aborts with no strobe.
- R4: After the prefix and A0h, the next write gives kind 3 (program), with op_addr and op_data taken from that write.
- R5: After the prefix and 40h, the next two writes give kind 4 (double-word program) only if their addresses differ in bit 0 alone. The first write appears on op_addr/op_data and the second on op_addr2/op_data2. Any other pair aborts with no strobe.
- R6: After the prefix and 60h, the fourth write decodes as follows. 01h gives kind 6 (protect), D0h gives kind 7 (unprotect) and 2Fh gives kind 8 (lock); each reports the write's address. 03h gives kind 5 (configuration write), with op_data equal to address bits 15:0. Any other code aborts.
- R7: After the prefix and 80h, a second prefix is required. The sixth write then decodes as 30h, giving kind 9 (block erase), or 10h, giving kind 10 (bank erase), with op_addr taken from that write. Anything else aborts.
- R8: Without a prefix, B0h at any address gives kind 11 (suspend) and 30h gives kind 12 (resume).
- R9: While bypass_on is 1, A0h or 40h starts a program or double-word program without a prefix. The pair 90h then 00h gives kind 14 and clears bypass_on. An abort leaves bypass_on unchanged.
- R10: Prefix, set-up and query addresses compare address bits 10:0 only. Command codes compare data bits 7:0 only.
- R11: A cycle that does not fit the pending sequence gives no strobe and sets rd_mode to 0.
- R12: A mismatching cycle that is AAh at 555h counts as the first cycle of a new prefix.
- R13: A strobe appears at the clock edge that samples the final write, lasts one cycle for that write, and never appears without a write. Cycles with wr_en low do not advance a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One bus write cycle this clock |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | DATA_W | Write cycle data |
| op_valid | output | 1 | One-cycle operation strobe |
| op_kind | output | 4 | Operation kind, codes 0 to 14 as in the requirements |
| op_addr | output | ADDR_W | Operation address (first word for double-word) |
| op_data | output | DATA_W | Operation data (address bits 15:0 for configuration write) |
| op_addr2 | output | ADDR_W | Address of the final write cycle |
| op_data2 | output | DATA_W | Data of the final write cycle |
| rd_mode | output | 2 | Read mode: 0 array, 1 autoselect, 2 query |
| bypass_on | output | 1 | Bypass mode active |

## Verification
The assertions check several rules on every cycle. A strobe never appears without a write. Every abort leaves the array read mode and no strobe. Bypass changes only together with its enter or exit strobe. Double-word addresses differ in bit 0 alone, and an autoselect strobe always comes with the autoselect read mode. Only the bench scenarios can show that each set-up, confirm and first-cycle code decodes to the right kind, that idle gaps are harmless, and that an aborting AAh at 555h restarts the prefix. The bench sweeps all 256 codes in the first, third and fourth positions to cover these cases.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [3:0] {
    OP_RD     = 4'd0,
    OP_AS     = 4'd1,
    OP_QRY    = 4'd2,
    OP_PG     = 4'd3,
    OP_DW     = 4'd4,
    OP_CFG    = 4'd5,
    OP_PROT   = 4'd6,
    OP_UNPROT = 4'd7,
    OP_LOCK   = 4'd8,
    OP_BERASE = 4'd9,
    OP_KERASE = 4'd10,
    OP_SUSP   = 4'd11,
    OP_RES    = 4'd12,
    OP_EBY    = 4'd13,
    OP_XBY    = 4'd14
  } op_e;

  typedef enum logic [1:0] {
    RM_ARRAY   = 2'd0,
    RM_AUTOSEL = 2'd1,
    RM_QUERY   = 2'd2
  } rmode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_SETUP, ST_PG, ST_DW1, ST_DW2,
    ST_GRP, ST_ER_U1, ST_ER_U2, ST_ER_CONF, ST_XBY
  } st_e;

  localparam logic [CODE_W-1:0] C_KEY1   = 8'hAA;
  localparam logic [CODE_W-1:0] C_KEY2   = 8'h55;
  localparam logic [CODE_W-1:0] C_RESET  = 8'hF0;
  localparam logic [CODE_W-1:0] C_IDENT  = 8'h90;
  localparam logic [CODE_W-1:0] C_QUERY  = 8'h98;
  localparam logic [CODE_W-1:0] C_PROG   = 8'hA0;
  localparam logic [CODE_W-1:0] C_DWPROG = 8'h40;
  localparam logic [CODE_W-1:0] C_GROUP  = 8'h60;
  localparam logic [CODE_W-1:0] C_ERSET  = 8'h80;
  localparam logic [CODE_W-1:0] C_BYPASS = 8'h20;
  localparam logic [CODE_W-1:0] C_SUSP   = 8'hB0;
  localparam logic [CODE_W-1:0] C_BLKER  = 8'h30;
  localparam logic [CODE_W-1:0] C_BNKER  = 8'h10;
  localparam logic [CODE_W-1:0] C_XBYOK  = 8'h00;
  localparam logic [CODE_W-1:0] C_PROT   = 8'h01;
  localparam logic [CODE_W-1:0] C_UNPROT = 8'hD0;
  localparam logic [CODE_W-1:0] C_LOCK   = 8'h2F;
  localparam logic [CODE_W-1:0] C_CFGWR  = 8'h03;

  // Next read mode after a completed operation
  function automatic rmode_e mode_after(input op_e k);
    case (k)
      OP_AS:   return RM_AUTOSEL;
      OP_QRY:  return RM_QUERY;
      default: return RM_ARRAY;
    endcase
  endfunction
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int KEY_W = 11
) (
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [CODE_W-1:0] code,
  output logic              is_key1,
  output logic              is_key2,
  output logic              at_setup,
  output logic              at_query
);
  localparam logic [KEY_W-1:0] A_MAIN  = KEY_W'(12'h555);
  localparam logic [KEY_W-1:0] A_ALT   = KEY_W'(12'h2AA);
  localparam logic [KEY_W-1:0] A_QUERY = KEY_W'(12'h055);

  always_comb begin
    at_setup = (key_addr == A_MAIN);
    at_query = (key_addr == A_QUERY);
    is_key1  = at_setup && (code == C_KEY1);
    is_key2  = (key_addr == A_ALT) && (code == C_KEY2);
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              is_key1,
  input  logic              is_key2,
  input  logic              at_setup,
  input  logic              at_query,
  input  logic              bypass_on,
  output logic              ev_fire,
  output op_e               ev_kind,
  output logic              ev_abort,
  output logic              op_valid,
  output op_e               op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [ADDR_W-1:0] op_addr2,
  output logic [DATA_W-1:0] op_data2
);
  st_e               st, st_n;
  logic              dw_latch;
  logic [ADDR_W-1:0] dw_addr;
  logic [DATA_W-1:0] dw_data;
  logic [CODE_W-1:0] code;

  assign code = data[CODE_W-1:0];

  // Two words of a pair may differ in address bit 0 only
  function automatic logic dw_pair_ok(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return (a ^ b) == ADDR_W'(1);
  endfunction

  always_comb begin
    st_n     = st;
    ev_fire  = 1'b0;
    ev_kind  = OP_RD;
    ev_abort = 1'b0;
    dw_latch = 1'b0;
    if (wr_en) begin
      case (st)
        ST_IDLE: begin
          if (is_key1)                               st_n = ST_UNL1;
          else if (code == C_RESET)                  begin ev_fire = 1'b1; ev_kind = OP_RD;   end
          else if (code == C_QUERY && at_query)      begin ev_fire = 1'b1; ev_kind = OP_QRY;  end
          else if (code == C_SUSP)                   begin ev_fire = 1'b1; ev_kind = OP_SUSP; end
          else if (code == C_BLKER)                  begin ev_fire = 1'b1; ev_kind = OP_RES;  end
          else if (bypass_on && code == C_PROG)      st_n = ST_PG;
          else if (bypass_on && code == C_DWPROG)    st_n = ST_DW1;
          else if (bypass_on && code == C_IDENT)     st_n = ST_XBY;
          else                                       ev_abort = 1'b1;
        end
        ST_UNL1:  if (is_key2) st_n = ST_SETUP; else ev_abort = 1'b1;
        ST_SETUP: begin
          if (!at_setup) ev_abort = 1'b1;
          else begin
            case (code)
              C_RESET:  begin ev_fire = 1'b1; ev_kind = OP_RD;  end
              C_IDENT:  begin ev_fire = 1'b1; ev_kind = OP_AS;  end
              C_BYPASS: begin ev_fire = 1'b1; ev_kind = OP_EBY; end
              C_PROG:   st_n = ST_PG;
              C_DWPROG: st_n = ST_DW1;
              C_GROUP:  st_n = ST_GRP;
              C_ERSET:  st_n = ST_ER_U1;
              default:  ev_abort = 1'b1;
            endcase
          end
        end
        ST_PG:  begin ev_fire = 1'b1; ev_kind = OP_PG; end
        ST_DW1: begin dw_latch = 1'b1; st_n = ST_DW2; end
        ST_DW2: begin
          if (dw_pair_ok(dw_addr, addr)) begin ev_fire = 1'b1; ev_kind = OP_DW; end
          else ev_abort = 1'b1;
        end
        ST_GRP: begin
          case (code)
            C_PROT:   begin ev_fire = 1'b1; ev_kind = OP_PROT;   end
            C_UNPROT: begin ev_fire = 1'b1; ev_kind = OP_UNPROT; end
            C_LOCK:   begin ev_fire = 1'b1; ev_kind = OP_LOCK;   end
            C_CFGWR:  begin ev_fire = 1'b1; ev_kind = OP_CFG;    end
            default:  ev_abort = 1'b1;
          endcase
        end
        ST_ER_U1: if (is_key1) st_n = ST_ER_U2;   else ev_abort = 1'b1;
        ST_ER_U2: if (is_key2) st_n = ST_ER_CONF; else ev_abort = 1'b1;
        ST_ER_CONF: begin
          if (code == C_BLKER)      begin ev_fire = 1'b1; ev_kind = OP_BERASE; end
          else if (code == C_BNKER) begin ev_fire = 1'b1; ev_kind = OP_KERASE; end
          else ev_abort = 1'b1;
        end
        ST_XBY: begin
          if (code == C_XBYOK) begin ev_fire = 1'b1; ev_kind = OP_XBY; end
          else ev_abort = 1'b1;
        end
        default: ev_abort = 1'b1;
      endcase
      if (ev_fire)  st_n = ST_IDLE;
      if (ev_abort) st_n = is_key1 ? ST_UNL1 : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_valid <= 1'b0;
      op_kind  <= OP_RD;
      op_addr  <= '0;
      op_data  <= '0;
      op_addr2 <= '0;
      op_data2 <= '0;
      dw_addr  <= '0;
      dw_data  <= '0;
    end else begin
      st       <= st_n;
      op_valid <= ev_fire;
      if (dw_latch) begin
        dw_addr <= addr;
        dw_data <= data;
      end
      if (ev_fire) begin
        op_kind  <= ev_kind;
        op_addr  <= (ev_kind == OP_DW) ? dw_addr : addr;
        op_data  <= (ev_kind == OP_DW)  ? dw_data :
                    (ev_kind == OP_CFG) ? addr[DATA_W-1:0] : data;
        op_addr2 <= addr;
        op_data2 <= data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_mode.sv
module flash_cmd_mode
  import flash_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_fire,
  input  op_e    ev_kind,
  input  logic   ev_abort,
  output rmode_e rd_mode,
  output logic   bypass_on
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_mode   <= RM_ARRAY;
      bypass_on <= 1'b0;
    end else if (ev_abort) begin
      rd_mode <= RM_ARRAY;
    end else if (ev_fire) begin
      rd_mode <= mode_after(ev_kind);
      if (ev_kind == OP_EBY) bypass_on <= 1'b1;
      if (ev_kind == OP_XBY) bypass_on <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int KEY_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              op_valid,
  output logic [3:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [ADDR_W-1:0] op_addr2,
  output logic [DATA_W-1:0] op_data2,
  output logic [1:0]        rd_mode,
  output logic              bypass_on
);
  logic   is_key1, is_key2, at_setup, at_query;
  logic   ev_fire, ev_abort;
  op_e    ev_kind, kind_q;
  rmode_e mode_q;

  flash_cmd_decode #(.KEY_W(KEY_W)) u_dec (
    .key_addr (wr_addr[KEY_W-1:0]),
    .code     (wr_data[CODE_W-1:0]),
    .is_key1  (is_key1),
    .is_key2  (is_key2),
    .at_setup (at_setup),
    .at_query (at_query)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (wr_addr),
    .data      (wr_data),
    .is_key1   (is_key1),
    .is_key2   (is_key2),
    .at_setup  (at_setup),
    .at_query  (at_query),
    .bypass_on (bypass_on),
    .ev_fire   (ev_fire),
    .ev_kind   (ev_kind),
    .ev_abort  (ev_abort),
    .op_valid  (op_valid),
    .op_kind   (kind_q),
    .op_addr   (op_addr),
    .op_data   (op_data),
    .op_addr2  (op_addr2),
    .op_data2  (op_data2)
  );

  flash_cmd_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_fire   (ev_fire),
    .ev_kind   (ev_kind),
    .ev_abort  (ev_abort),
    .rd_mode   (mode_q),
    .bypass_on (bypass_on)
  );

  assign op_kind = kind_q;
  assign rd_mode = mode_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              op_valid,
  input logic [3:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic [ADDR_W-1:0] op_addr2,
  input logic [1:0]        rd_mode,
  input logic              bypass_on,
  input logic              ev_abort
);
  // R13
  strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_en));

  // R11
  abort_to_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (rd_mode == 2'd0 && !op_valid));

  // R9
  bypass_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_on) |-> (op_valid && op_kind == 4'd13));

  // R9
  bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_on) |-> (op_valid && op_kind == 4'd14));

  // R5
  dw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 4'd4) |-> ((op_addr ^ op_addr2) == ADDR_W'(1)));

  // R3
  autosel_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 4'd1) |-> (rd_mode == 2'd1));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .op_addr   (op_addr),
  .op_addr2  (op_addr2),
  .rd_mode   (rd_mode),
  .bypass_on (bypass_on),
  .ev_abort  (ev_abort)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        op_valid;
  logic [3:0]  op_kind;
  logic [19:0] op_addr, op_addr2;
  logic [15:0] op_data, op_data2;
  logic [1:0]  rd_mode;
  logic        bypass_on;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .op_addr2(op_addr2), .op_data2(op_data2), .rd_mode(rd_mode), .bypass_on(bypass_on)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus write; outputs are sampled 1 ns after the edge that captures it
  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic prefix(input logic [19:0] hi);
    wr(20'h555 | hi, 16'h00AA);
    wr(20'h2AA | hi, 16'h0055);
  endtask

  task automatic expect_op(input string tag, input int kind, input logic [19:0] a, input logic [15:0] d);
    check({tag, " valid"}, op_valid, 1);
    check({tag, " kind"}, op_kind, kind);
    check({tag, " addr"}, op_addr, a);
    check({tag, " data"}, op_data, d);
  endtask

  task automatic expect_none(input string tag);
    check({tag, " no strobe"}, op_valid, 0);
  endtask

  // third-cycle code: >=0 kind, -1 abort, -2 waits for more
  function automatic int exp_setup(input int c);
    case (c)
      'hF0: return 0;
      'h90: return 1;
      'h20: return 13;
      'hA0, 'h40, 'h60, 'h80: return -2;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_first(input int c);
    case (c)
      'hF0: return 0;
      'h98: return 2;
      'hB0: return 11;
      'h30: return 12;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_group(input int c);
    case (c)
      'h01: return 6;
      'hD0: return 7;
      'h2F: return 8;
      'h03: return 5;
      default: return -1;
    endcase
  endfunction

  initial begin
    // R1: reset state
    idle(3);
    check("R1 valid in reset", op_valid, 0);
    check("R1 mode in reset", rd_mode, 0);
    check("R1 bypass in reset", bypass_on, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check("R1 valid after reset", op_valid, 0);
    check("R1 mode after reset", rd_mode, 0);
    check("R1 bypass after reset", bypass_on, 0);

    // R3 / R10: sweep every third-cycle code, upper address/data bits noisy
    for (int c = 0; c < 256; c++) begin
      logic [19:0] hi;
      int e;
      hi = 20'(c % 16) << 12;
      e = exp_setup(c);
      prefix(hi);
      wr(20'h555 | hi, {8'hC3, 8'(c)});
      if (e >= 0) begin
        check($sformatf("R3 code %0h valid", c), op_valid, 1);
        check($sformatf("R3 code %0h kind", c), op_kind, e);
        check($sformatf("R3 code %0h mode", c), rd_mode, (e == 1) ? 1 : 0);
        check($sformatf("R3 code %0h bypass", c), bypass_on, (e == 13) ? 1 : 0);
        idle(1);
        check("R13 strobe one cycle", op_valid, 0);
        if (e == 13) begin
          wr(20'h0, 16'h0090);
          wr(20'h0, 16'h0000);
          expect_op("R9 exit bypass", 14, 20'h0, 16'h0000);
          check("R9 bypass cleared", bypass_on, 0);
        end
        if (e == 1) begin
          wr(20'h7, 16'h00F0);
          check("R2 reset from autoselect mode", rd_mode, 0);
        end
      end else if (e == -1) begin
        expect_none($sformatf("R11 code %0h", c));
        check($sformatf("R11 code %0h mode", c), rd_mode, 0);
      end else begin
        expect_none($sformatf("R3 code %0h pending", c));
        if (c == 'hA0) begin
          wr(20'h12345, 16'hBEEF);
          expect_op("R4 program", 3, 20'h12345, 16'hBEEF);
        end else if (c == 'h40) begin
          wr(20'h00100, 16'h1234);
          expect_none("R5 first word");
          wr(20'h00101, 16'h5678);
          expect_op("R5 double word", 4, 20'h00100, 16'h1234);
          check("R5 second addr", op_addr2, 20'h00101);
          check("R5 second data", op_data2, 16'h5678);
        end else begin
          wr(20'h0, 16'hFFFF);
          expect_none("R11 bad continuation");
        end
      end
    end

    // R10: wrong low address bit in setup cycle aborts
    prefix(20'h0);
    wr(20'h554, 16'h0090);
    expect_none("R10 setup address");

    // R2 / R8 / R11: every first-cycle code at address 055h
    for (int c = 0; c < 256; c++) begin
      int e;
      e = exp_first(c);
      wr(20'hF8055, {8'h7E, 8'(c)});
      if (e >= 0) begin
        expect_op($sformatf("R2/R8 first %0h", c), e, 20'hF8055, {8'h7E, 8'(c)});
        check($sformatf("R2 first %0h mode", c), rd_mode, (e == 2) ? 2 : 0);
      end else begin
        expect_none($sformatf("R11 first %0h", c));
        check($sformatf("R11 first %0h mode", c), rd_mode, 0);
      end
    end
    wr(20'h3, 16'h00B0);
    expect_op("R8 suspend any address", 11, 20'h3, 16'h00B0);

    // R6: every fourth-cycle code after 60h
    for (int c = 0; c < 256; c++) begin
      int e;
      e = exp_group(c);
      prefix(20'h0);
      wr(20'h555, 16'h0060);
      wr(20'h3ABCD, {8'h00, 8'(c)});
      if (e == 5)      expect_op("R6 config write", 5, 20'h3ABCD, 16'hABCD);
      else if (e >= 0) expect_op($sformatf("R6 code %0h", c), e, 20'h3ABCD, {8'h00, 8'(c)});
      else             expect_none($sformatf("R6 code %0h", c));
    end

    // R7: erase flows
    prefix(20'h0); wr(20'h555, 16'h0080); prefix(20'h0);
    wr(20'h48000, 16'h0030);
    expect_op("R7 block erase", 9, 20'h48000, 16'h0030);
    prefix(20'h0); wr(20'h555, 16'h0080); prefix(20'h0);
    wr(20'hC0000, 16'h0010);
    expect_op("R7 bank erase", 10, 20'hC0000, 16'h0010);
    prefix(20'h0); wr(20'h555, 16'h0080); prefix(20'h0);
    wr(20'h40000, 16'h0020);
    expect_none("R7 bad confirm");
    prefix(20'h0); wr(20'h555, 16'h0080);
    wr(20'h555, 16'h00AA); wr(20'h2AB, 16'h0055);
    expect_none("R7 bad second prefix");
    wr(20'h40000, 16'h0030);
    expect_op("R7 after abort is resume", 12, 20'h40000, 16'h0030);

    // R5: pair differing beyond bit 0 aborts
    prefix(20'h0); wr(20'h555, 16'h0040);
    wr(20'h00100, 16'h1111); wr(20'h00102, 16'h2222);
    expect_none("R5 bad pair");

    // R9: bypass behaviour
    prefix(20'h0); wr(20'h555, 16'h0020);
    check("R9 bypass set", bypass_on, 1);
    wr(20'h9, 16'h00A0); wr(20'h0ABCD, 16'h0F0F);
    expect_op("R9 program no prefix", 3, 20'h0ABCD, 16'h0F0F);
    wr(20'h9, 16'h0040); wr(20'h0FFFE, 16'h1010); wr(20'h0FFFF, 16'h2020);
    expect_op("R9 double word no prefix", 4, 20'h0FFFE, 16'h1010);
    wr(20'h9, 16'h0077);
    expect_none("R9 abort in bypass");
    check("R9 bypass kept on abort", bypass_on, 1);
    wr(20'h9, 16'h0090); wr(20'h9, 16'h0001);
    expect_none("R9 bad exit");
    check("R9 bypass kept on bad exit", bypass_on, 1);
    wr(20'h9, 16'h0090); wr(20'h9, 16'h0000);
    expect_op("R9 exit", 14, 20'h9, 16'h0000);
    check("R9 bypass off", bypass_on, 0);
    wr(20'h9, 16'h00A0);
    expect_none("R9 no program without bypass");
    wr(20'h1234, 16'h5555);
    expect_none("R9 following write no program");

    // R12: aborting AAh at 555h restarts the prefix
    prefix(20'h0); wr(20'h555, 16'h00AA);
    expect_none("R12 setup mismatch");
    wr(20'h2AA, 16'h0055); wr(20'h555, 16'h00F0);
    expect_op("R12 restarted prefix", 0, 20'h555, 16'h00F0);
    wr(20'h555, 16'h00AA); wr(20'h555, 16'h00AA);
    wr(20'h2AA, 16'h0055); wr(20'h555, 16'h0090);
    expect_op("R12 double key1", 1, 20'h555, 16'h0090);

    // R11: abort from autoselect mode returns to array
    wr(20'h0, 16'h0012);
    expect_none("R11 stray cycle");
    check("R11 mode array after abort", rd_mode, 0);

    // R13: idle gaps do not break a sequence
    wr(20'h555, 16'h00AA); idle(3);
    wr(20'h2AA, 16'h0055); idle(4);
    check("R13 no strobe during gap", op_valid, 0);
    wr(20'h555, 16'h0098 ^ 16'h0008);
    expect_op("R13 gapped autoselect", 1, 20'h555, 16'h0090);
    idle(1);
    check("R13 strobe drops", op_valid, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule